// File: doc/BRIEF.md
# Memoized Tag Broadcast Bus

This block carries destination tags from a producer to a set of stored source-tag comparators, as the wakeup path of an issue queue does. Each tag is cut into a low field and a high field. The low field goes out on every broadcast. The high field goes out only when it differs from the high field that last went out on the same bus. A one-bit strobe, `driveUpper`, marks the cycles in which the high wires carry a new value. In every other cycle the high wires keep the value they last carried, so they do not toggle.

Each receiving comparator keeps the result of its last high-field compare in a flop. In a cycle with the strobe raised, it uses the fresh high compare and also captures it. In a cycle with the strobe low, it uses the saved result. In both cases the high result is combined with a fresh low-field compare. When a new source tag is written into a comparator, its saved high result is recomputed against the high value that the bus will hold after the current cycle. Later low-only broadcasts then resolve correctly.

The scheme does not delay, reorder or drop any broadcast. A full match appears in the same cycle as the broadcast that causes it. Tag width, the width of the low field and the comparator count are parameters. Several buses are built as separate instances.

Top module: `memoTagBus`

## Requirements
- R1: After reset the bus holds no remembered high value. The first valid broadcast therefore raises `driveUpper`. While `bcastValid` is low, `driveUpper` is 0, and `busUpper` reads 0 until the first broadcast.
- R2: On a valid broadcast, `driveUpper` is 1 exactly when the high field `bcastTag[TAG_W-1:LOW_W]` differs from the high value last driven on the bus, or when no value has been driven since reset.
- R3: During a valid broadcast, `busLower` equals `bcastTag[LOW_W-1:0]` in the same cycle.
- R4: In a cycle with `driveUpper` raised, `busUpper` equals the broadcast's high field. In every other cycle, `busUpper` keeps the high value last driven.
- R5: `matchVec[i]` is 1 in the cycle of a valid broadcast exactly when the full broadcast tag equals the source tag stored in comparator i. This holds whether or not the high field was re-driven. It includes tags that share the low field but differ in the high field.
- R6: While `bcastValid` is low, `matchVec` is all zeros.
- R7: A source tag written while the bus holds a remembered high value matches a later low-only broadcast of that tag. A source tag whose high field differs from the remembered value does not match a later low-only broadcast that shares its low field.
- R8: Cycles with `bcastValid` low leave the remembered high value and all comparator state unchanged. A broadcast that follows idle cycles and repeats the last high field does not raise `driveUpper`, and it still matches.
- R9: A write (`wrEn` high, entry `wrIdx`, tag `wrTag`) takes effect at the next clock edge. In the cycle of the write, the match for that entry reflects the old tag. This holds even when the same cycle carries a broadcast that raises `driveUpper`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bcastValid | input | 1 | A destination tag is broadcast this cycle |
| bcastTag | input | TAG_W | Destination tag being broadcast |
| wrEn | input | 1 | Write a new source tag into a comparator |
| wrIdx | input | $clog2(NUM_ENT) | Comparator selected by the write |
| wrTag | input | TAG_W | Source tag to store |
| busLower | output | LOW_W | Low tag wires, driven on every broadcast |
| busUpper | output | TAG_W-LOW_W | High tag wires, held when not re-driven |
| driveUpper | output | 1 | High wires carry a new value this cycle |
| matchVec | output | NUM_ENT | Per-comparator full-tag match |

## Verification
The bench builds the block with 7-bit tags, a 4-bit low field and four comparators. With only three high bits, tags such as 35, 32 and 41 share a high value, and long low-only runs follow naturally. With a small comparator count, tags that share a low field but differ in the high field (35 and 99, 43 and 107) can sit in neighbouring entries. These pairs expose any comparator that trusts a stale high result. Writes are placed in low-only cycles and in driving cycles, so both sources of the recomputed high result are exercised.

// File: rtl/memoBusPkg.sv
package memoBusPkg;
  // Strobes passed from the bus driver to the comparator array.
  typedef struct packed {
    logic bcast;       // a tag is on the bus this cycle
    logic driveUpper;  // high wires carry a fresh value this cycle
    logic upperKnown;  // busUpper holds a meaningful value after this cycle
  } busStrobeT;
endpackage

// File: rtl/memoBusCtrl.sv
module memoBusCtrl
  import memoBusPkg::*;
#(
  parameter int TAG_W = 7,
  parameter int LOW_W = 4,
  localparam int UP_W = TAG_W - LOW_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bcastValid,
  input  logic [TAG_W-1:0] bcastTag,
  output busStrobeT        strobe,
  output logic [LOW_W-1:0] busLower,
  output logic [UP_W-1:0]  busUpper
);
  logic            memoValid;
  logic [UP_W-1:0] memoUpper;
  logic [UP_W-1:0] tagUpper;

  assign tagUpper = bcastTag[TAG_W-1:LOW_W];

  always_comb begin
    strobe.bcast      = bcastValid;
    strobe.driveUpper = bcastValid && (!memoValid || (tagUpper != memoUpper));
    strobe.upperKnown = memoValid || strobe.driveUpper;
  end

  assign busLower = bcastTag[LOW_W-1:0];
  assign busUpper = strobe.driveUpper ? tagUpper : memoUpper;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memoValid <= 1'b0;
      memoUpper <= '0;
    end else if (strobe.driveUpper) begin
      memoValid <= 1'b1;
      memoUpper <= tagUpper;
    end
  end
endmodule

// File: rtl/memoBusRecv.sv
module memoBusRecv
  import memoBusPkg::*;
#(
  parameter int TAG_W   = 7,
  parameter int LOW_W   = 4,
  parameter int NUM_ENT = 4,
  localparam int UP_W  = TAG_W - LOW_W,
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  busStrobeT          strobe,
  input  logic [LOW_W-1:0]   busLower,
  input  logic [UP_W-1:0]    busUpper,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [TAG_W-1:0]   wrTag,
  output logic [NUM_ENT-1:0] matchVec
);
  logic wrUpperHit;
  // busUpper already shows the value the bus remembers after this cycle
  assign wrUpperHit = strobe.upperKnown && (wrTag[TAG_W-1:LOW_W] == busUpper);

  for (genvar i = 0; i < NUM_ENT; i++) begin : gEnt
    logic [TAG_W-1:0] srcTag;
    logic             upHit;
    logic             lowerEq;
    logic             upperEq;
    logic             upSel;
    logic             wrThis;

    assign wrThis  = wrEn && (wrIdx == IDX_W'(i));
    assign lowerEq = (busLower == srcTag[LOW_W-1:0]);
    assign upperEq = (busUpper == srcTag[TAG_W-1:LOW_W]);
    assign upSel   = strobe.driveUpper ? upperEq : upHit;
    assign matchVec[i] = strobe.bcast && lowerEq && upSel;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        srcTag <= '0;
        upHit  <= 1'b0;
      end else if (wrThis) begin
        srcTag <= wrTag;
        upHit  <= wrUpperHit;
      end else if (strobe.driveUpper) begin
        upHit  <= upperEq;
      end
    end
  end
endmodule

// File: rtl/memoTagBus.sv
module memoTagBus
  import memoBusPkg::*;
#(
  parameter int TAG_W   = 7,
  parameter int LOW_W   = 4,
  parameter int NUM_ENT = 4,
  localparam int UP_W  = TAG_W - LOW_W,
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bcastValid,
  input  logic [TAG_W-1:0]   bcastTag,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [TAG_W-1:0]   wrTag,
  output logic [LOW_W-1:0]   busLower,
  output logic [UP_W-1:0]    busUpper,
  output logic               driveUpper,
  output logic [NUM_ENT-1:0] matchVec
);
  busStrobeT strobe;

  memoBusCtrl #(.TAG_W(TAG_W), .LOW_W(LOW_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bcastValid(bcastValid), .bcastTag(bcastTag),
    .strobe(strobe), .busLower(busLower), .busUpper(busUpper)
  );

  memoBusRecv #(.TAG_W(TAG_W), .LOW_W(LOW_W), .NUM_ENT(NUM_ENT)) uRecv (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busLower(busLower),
    .busUpper(busUpper), .wrEn(wrEn), .wrIdx(wrIdx), .wrTag(wrTag),
    .matchVec(matchVec)
  );

  assign driveUpper = strobe.driveUpper;
endmodule

// File: rtl/memoTagBusChk.sv
module memoTagBusChk #(
  parameter int TAG_W   = 7,
  parameter int LOW_W   = 4,
  parameter int NUM_ENT = 4,
  localparam int UP_W = TAG_W - LOW_W
) (
  input logic               clk,
  input logic               rstN,
  input logic               bcastValid,
  input logic [TAG_W-1:0]   bcastTag,
  input logic [LOW_W-1:0]   busLower,
  input logic [UP_W-1:0]    busUpper,
  input logic               driveUpper,
  input logic [NUM_ENT-1:0] matchVec
);
  // Observer of the port-level bus history
  logic            seen;
  logic [UP_W-1:0] lastUp;
  logic [UP_W-1:0] tagUp;
  assign tagUp = bcastTag[TAG_W-1:LOW_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seen   <= 1'b0;
      lastUp <= '0;
    end else if (driveUpper) begin
      seen   <= 1'b1;
      lastUp <= busUpper;
    end
  end

  p_first_drive_r1: assert property (@(posedge clk) disable iff (!rstN)
    (bcastValid && !seen) |-> driveUpper);
  p_drive_needs_bcast_r1: assert property (@(posedge clk) disable iff (!rstN)
    driveUpper |-> bcastValid);
  p_no_redrive_r2: assert property (@(posedge clk) disable iff (!rstN)
    (bcastValid && seen && tagUp == lastUp) |-> !driveUpper);
  p_change_drive_r2: assert property (@(posedge clk) disable iff (!rstN)
    (bcastValid && seen && tagUp != lastUp) |-> driveUpper);
  p_lower_r3: assert property (@(posedge clk) disable iff (!rstN)
    bcastValid |-> busLower == bcastTag[LOW_W-1:0]);
  p_upper_value_r4: assert property (@(posedge clk) disable iff (!rstN)
    driveUpper |-> busUpper == tagUp);
  p_upper_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (seen && !driveUpper) |-> busUpper == lastUp);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !bcastValid |-> matchVec == '0);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (seen && !bcastValid) |=> $stable(busUpper) || driveUpper);
endmodule

bind memoTagBus memoTagBusChk #(.TAG_W(TAG_W), .LOW_W(LOW_W), .NUM_ENT(NUM_ENT)) uChk (
  .clk(clk), .rstN(rstN), .bcastValid(bcastValid), .bcastTag(bcastTag),
  .busLower(busLower), .busUpper(busUpper), .driveUpper(driveUpper),
  .matchVec(matchVec)
);

// File: tb/tb_memoTagBus.sv
module tb_memoTagBus;
  localparam int TAG_W = 7;
  localparam int LOW_W = 4;
  localparam int NUM_ENT = 4;
  localparam int UP_W = TAG_W - LOW_W;
  localparam int IDX_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bcastValid = 1'b0;
  logic [TAG_W-1:0] bcastTag = '0;
  logic wrEn = 1'b0;
  logic [IDX_W-1:0] wrIdx = '0;
  logic [TAG_W-1:0] wrTag = '0;
  logic [LOW_W-1:0] busLower;
  logic [UP_W-1:0] busUpper;
  logic driveUpper;
  logic [NUM_ENT-1:0] matchVec;

  always #2 clk = ~clk;  // 250 MHz

  memoTagBus #(.TAG_W(TAG_W), .LOW_W(LOW_W), .NUM_ENT(NUM_ENT)) dut (.*);

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  // Bench model built from the requirements
  logic            mValid = 1'b0;
  logic [UP_W-1:0] mUp = '0;
  logic [TAG_W-1:0] shadow [NUM_ENT];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle: optional broadcast and optional write, checked mid-cycle
  task automatic step(bit bv, logic [TAG_W-1:0] tag, bit we,
                      logic [IDX_W-1:0] idx, logic [TAG_W-1:0] wt, string req);
    logic expDrive;
    logic [UP_W-1:0] expUp;
    logic [NUM_ENT-1:0] expMatch;
    @(negedge clk);
    bcastValid = bv; bcastTag = tag; wrEn = we; wrIdx = idx; wrTag = wt;
    #1;
    expDrive = bv && (!mValid || tag[TAG_W-1:LOW_W] != mUp);
    expUp = expDrive ? tag[TAG_W-1:LOW_W] : mUp;
    for (int i = 0; i < NUM_ENT; i++) expMatch[i] = bv && (tag == shadow[i]);
    chk({req, " driveUpper"}, 32'(driveUpper), 32'(expDrive));
    chk({req, " busUpper"}, 32'(busUpper), 32'(expUp));
    chk({req, " matchVec"}, 32'(matchVec), 32'(expMatch));
    if (bv) chk({req, " busLower R3"}, 32'(busLower), 32'(tag[LOW_W-1:0]));
    if (expDrive) begin mValid = 1'b1; mUp = expUp; end
    if (we) shadow[idx] = wt;
  endtask

  task automatic idle(int n, string req);
    for (int k = 0; k < n; k++) step(1'b0, '0, 1'b0, '0, '0, req);
  endtask

  task automatic testReset();  // R1, R6
    idle(2, "R1 R6 idle after reset");
    step(1'b1, 7'd35, 1'b0, '0, '0, "R1 first broadcast");
  endtask

  task automatic testStream();  // R2, R5
    step(1'b0, '0, 1'b1, 2'd0, 7'd35, "R5 write e0");
    step(1'b0, '0, 1'b1, 2'd1, 7'd32, "R5 write e1");
    step(1'b0, '0, 1'b1, 2'd2, 7'd41, "R5 write e2");
    step(1'b0, '0, 1'b1, 2'd3, 7'd99, "R5 write e3");
    step(1'b1, 7'd35, 1'b0, '0, '0, "R2 R5 low-only 35");
    step(1'b1, 7'd32, 1'b0, '0, '0, "R2 R5 low-only 32");
    step(1'b1, 7'd41, 1'b0, '0, '0, "R2 R5 low-only 41");
    step(1'b1, 7'd99, 1'b0, '0, '0, "R2 R5 new high 99");
    step(1'b1, 7'd35, 1'b0, '0, '0, "R2 R5 back to 35");
    step(1'b1, 7'd3, 1'b0, '0, '0, "R5 shared low no match");
  endtask

  task automatic testIdle();  // R8
    step(1'b1, 7'd35, 1'b0, '0, '0, "R8 set high 010");
    idle(4, "R8 R6 idle hold");
    step(1'b1, 7'd32, 1'b0, '0, '0, "R8 repeat after idle");
  endtask

  task automatic testWriteLowOnly();  // R7
    step(1'b0, '0, 1'b1, 2'd3, 7'd43, "R7 write 43");
    step(1'b1, 7'd43, 1'b0, '0, '0, "R7 low-only hit");
    step(1'b0, '0, 1'b1, 2'd3, 7'd107, "R7 write 107");
    step(1'b1, 7'd43, 1'b0, '0, '0, "R7 low-only miss");
    step(1'b1, 7'd107, 1'b0, '0, '0, "R7 driven hit");
  endtask

  task automatic testSameCycle();  // R9
    step(1'b1, 7'd43, 1'b0, '0, '0, "R9 prime high 010");
    step(1'b1, 7'd35, 1'b1, 2'd0, 7'd20, "R9 old tag matches");
    step(1'b1, 7'd20, 1'b0, '0, '0, "R9 new tag matches");
    step(1'b1, 7'd85, 1'b1, 2'd1, 7'd84, "R9 write during drive");
    step(1'b1, 7'd84, 1'b0, '0, '0, "R9 low-only after drive write");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < NUM_ENT; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 reset driveUpper", 32'(driveUpper), 32'd0);
    chk("R1 reset busUpper", 32'(busUpper), 32'd0);
    chk("R6 reset matchVec", 32'(matchVec), 32'd0);
    rstN = 1'b1;
    testReset();
    testStream();
    testIdle();
    testWriteLowOnly();
    testSameCycle();
    idle(1, "R6 final idle");
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule